// File: doc/BRIEF.md
# Local-History Branch Target Buffer

This block is a small direct-mapped branch target buffer in which every entry carries its own two-level predictor. An entry remembers the identity of one branch, its last resolved target, a five-outcome shift record of that branch's own behaviour, and a bank of two-bit saturating counters. The shift record is the address into the counter bank. The counter it selects gives the taken or not-taken guess, and the same counter learns when the branch resolves. Any taken/not-taken pattern that repeats with a period of five or less therefore becomes fully predictable once it has warmed up.

The fetch side presents a PC and the target decoded from the instruction. The block answers in the same cycle with hit, predicted direction and predicted target. When no entry matches, the direction comes from a fixed rule: a branch to a lower address is guessed taken and a branch to the same or a higher address is guessed not-taken. The execute side reports each resolved branch through the update port. A resolution that matches an entry trains it. A resolution that misses claims the entry at its index. A build option trades the last three counters for the storage of the history record. In that layout, histories that would address a missing counter fall back to the direction rule on the stored target.

Top module: `lhist_btb`

## Requirements
- R1: The entry index is PC bits [ALIGN+IDX_W-1:ALIGN] and the tag is the PC bits above them. A lookup hits only when the entry at its index is valid and holds the same tag. On a hit, lk_target is the stored target. A resolution with another tag at the same index replaces the entry.
- R2: Counters encode 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken, 3 strongly taken. A taken outcome adds one and a not-taken outcome subtracts one, saturating at 3 and 0. A hit whose counter is present predicts the counter's bit 1.
- R3: On a resolution that hits, the counter addressed by the current history is updated first. Then the outcome (1 taken, 0 not-taken) enters history bit 0, and the oldest bit is dropped.
- R4: Repeating patterns of period five or less (TTNTN, all-taken, alternating, TTN, TNNN, all-not-taken) give zero mispredictions after 40 resolutions.
- R5: A resolution that misses allocates the entry: valid, new tag, the resolved target, and history 0. Every counter becomes 2 if up_tgt < up_pc and 1 otherwise. The outcome itself does not train the entry.
- R6: On a lookup miss, lk_taken is 1 exactly when lk_tgt < lk_pc, and lk_target equals lk_tgt.
- R7: With REDUCED=1 only counters 0 to 28 exist. A hit whose history is 29 to 31 predicts taken exactly when the stored target < lk_pc. A resolution at such a history only shifts the history.
- R8: After reset no entry is valid, so every lookup misses.
- R9: A resolution that hits overwrites the stored target with up_tgt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch PC being looked up |
| lk_tgt | input | PC_W | Decoded target of the fetched branch |
| lk_hit | output | 1 | An entry matches lk_pc |
| lk_taken | output | 1 | Predicted direction |
| lk_target | output | PC_W | Predicted target |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_tgt | input | PC_W | Resolved target |

## Verification
The assertions assume that the lookup inputs are stable around the sampling edge. They also assume that at most one resolution arrives per cycle, and that a resolution's PC is the one whose entry it is meant to train. The bench changes lookup and update inputs only just after a rising edge and holds up_valid for exactly one cycle per resolution. Before each resolution it looks up the same PC, so every direction, hit and target is compared against an arithmetic model of the entries. The full and reduced layouts are driven side by side with the same stimulus.

// File: rtl/lhb_pkg.sv
package lhb_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_t;

  // saturating two-bit step toward the resolved outcome
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic tk);
    if (tk) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    else    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  // starting counter value for a freshly allocated entry
  function automatic logic [1:0] ctr_seed(input logic backward);
    return backward ? 2'(CTR_WT) : 2'(CTR_WNT);
  endfunction

endpackage

// File: rtl/lhb_entry.sv
module lhb_entry
  import lhb_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int TAG_W  = 12,
  parameter int HIST_W = 5,
  parameter int NCTR   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              wr_alloc,
  input  logic              alloc_back,
  input  logic              up_taken,
  input  logic [TAG_W-1:0]  up_tag,
  input  logic [PC_W-1:0]   up_tgt,
  output logic              e_valid,
  output logic [TAG_W-1:0]  e_tag,
  output logic [PC_W-1:0]   e_target,
  output logic [HIST_W-1:0] e_hist,
  output logic [2*NCTR-1:0] e_ctrs
);

  logic [1:0] ctr_q [NCTR];
  logic       ctr_live;
  logic [1:0] sel_ctr;

  assign ctr_live = int'(e_hist) < NCTR;

  always_comb begin
    sel_ctr = 2'd0;
    for (int i = 0; i < NCTR; i++)
      if (e_hist == HIST_W'(i)) sel_ctr = ctr_q[i];
  end

  for (genvar g = 0; g < NCTR; g++) begin : g_flat
    assign e_ctrs[2*g +: 2] = ctr_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid  <= 1'b0;
      e_tag    <= '0;
      e_target <= '0;
      e_hist   <= '0;
      for (int i = 0; i < NCTR; i++) ctr_q[i] <= 2'd0;
    end else if (wr_alloc) begin
      e_valid  <= 1'b1;
      e_tag    <= up_tag;
      e_target <= up_tgt;
      e_hist   <= '0;
      for (int i = 0; i < NCTR; i++) ctr_q[i] <= ctr_seed(alloc_back);
    end else if (wr_hit) begin
      e_target <= up_tgt;
      for (int i = 0; i < NCTR; i++)
        if (e_hist == HIST_W'(i)) ctr_q[i] <= ctr_step(ctr_q[i], up_taken);
      e_hist <= {e_hist[HIST_W-2:0], up_taken};
    end
  end

  // R5: allocation leaves an empty history and seeded counters
  a_r5_alloc_init: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alloc |=> e_valid && e_hist == '0 && sel_ctr == ($past(alloc_back) ? 2'd2 : 2'd1));

  // R3: newest outcome lands in history bit 0
  a_r3_hist_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> e_hist[0] == $past(up_taken));

  // R9: a training hit refreshes the target
  a_r9_target_follow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> e_target == $past(up_tgt));

  // R2: strongly-taken counter stays there on a taken hit at the same history
  a_r2_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ctr_live && up_taken && sel_ctr == 2'd3 && e_hist == '1) |=> sel_ctr == 2'd3);

endmodule

// File: rtl/lhb_lookup.sv
module lhb_lookup #(
  parameter int PC_W   = 16,
  parameter int TAG_W  = 12,
  parameter int HIST_W = 5,
  parameter int NCTR   = 32
) (
  input  logic              e_valid,
  input  logic [TAG_W-1:0]  e_tag,
  input  logic [PC_W-1:0]   e_target,
  input  logic [HIST_W-1:0] e_hist,
  input  logic [2*NCTR-1:0] e_ctrs,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [PC_W-1:0]   lk_tgt,
  output logic              hit,
  output logic              taken,
  output logic [PC_W-1:0]   target
);

  function automatic logic goes_back(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tg);
    return tg < pc;
  endfunction

  logic       live;
  logic [1:0] sel;

  assign hit  = e_valid && (e_tag == lk_pc[PC_W-1 -: TAG_W]);
  assign live = int'(e_hist) < NCTR;

  always_comb begin
    sel = 2'd0;
    for (int i = 0; i < NCTR; i++)
      if (e_hist == HIST_W'(i)) sel = e_ctrs[2*i +: 2];
  end

  always_comb begin
    if (!hit)      taken = goes_back(lk_pc, lk_tgt);
    else if (live) taken = sel[1];
    else           taken = goes_back(lk_pc, e_target);
    target = hit ? e_target : lk_tgt;
  end

endmodule

// File: rtl/lhist_btb.sv
module lhist_btb #(
  parameter int PC_W    = 16,
  parameter int ALIGN   = 2,
  parameter int IDX_W   = 2,
  parameter int HIST_W  = 5,
  parameter bit REDUCED = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic [PC_W-1:0] lk_tgt,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_target,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_tgt
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - ALIGN - IDX_W;
  localparam int FULLN   = 1 << HIST_W;
  localparam int NCTR    = REDUCED ? FULLN - 3 : FULLN;

  logic              e_valid  [ENTRIES];
  logic [TAG_W-1:0]  e_tag    [ENTRIES];
  logic [PC_W-1:0]   e_target [ENTRIES];
  logic [HIST_W-1:0] e_hist   [ENTRIES];
  logic [2*NCTR-1:0] e_ctrs   [ENTRIES];

  logic [IDX_W-1:0]  up_idx, lk_idx;
  logic [TAG_W-1:0]  up_tag;
  logic              up_match, up_back;
  logic [ENTRIES-1:0] wr_hit_v, wr_alloc_v;

  assign up_idx   = up_pc[ALIGN +: IDX_W];
  assign lk_idx   = lk_pc[ALIGN +: IDX_W];
  assign up_tag   = up_pc[PC_W-1 -: TAG_W];
  assign up_match = e_valid[up_idx] && (e_tag[up_idx] == up_tag);
  assign up_back  = up_tgt < up_pc;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign wr_hit_v[g]   = up_valid &&  up_match && (up_idx == IDX_W'(g));
    assign wr_alloc_v[g] = up_valid && !up_match && (up_idx == IDX_W'(g));
    lhb_entry #(.PC_W(PC_W), .TAG_W(TAG_W), .HIST_W(HIST_W), .NCTR(NCTR)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_hit_v[g]), .wr_alloc(wr_alloc_v[g]), .alloc_back(up_back),
      .up_taken(up_taken), .up_tag(up_tag), .up_tgt(up_tgt),
      .e_valid(e_valid[g]), .e_tag(e_tag[g]), .e_target(e_target[g]),
      .e_hist(e_hist[g]), .e_ctrs(e_ctrs[g])
    );
  end

  lhb_lookup #(.PC_W(PC_W), .TAG_W(TAG_W), .HIST_W(HIST_W), .NCTR(NCTR)) u_lk (
    .e_valid(e_valid[lk_idx]), .e_tag(e_tag[lk_idx]), .e_target(e_target[lk_idx]),
    .e_hist(e_hist[lk_idx]), .e_ctrs(e_ctrs[lk_idx]),
    .lk_pc(lk_pc), .lk_tgt(lk_tgt),
    .hit(lk_hit), .taken(lk_taken), .target(lk_target)
  );

  // R1: one resolution touches at most one entry
  a_r1_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit_v | wr_alloc_v));

  // R6: miss falls back to the direction rule on the decoded target
  a_r6_miss_static: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_taken == (lk_tgt < lk_pc)) && (lk_target == lk_tgt));

  // R7: histories beyond the counter bank use the stored target's direction
  a_r7_reduced_static: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && int'(e_hist[lk_idx]) >= NCTR) |-> lk_taken == (lk_target < lk_pc));

endmodule

// File: tb/sim_lhist_btb.sv
module sim_lhist_btb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lk_pc = '0, lk_tgt = '0, up_pc = '0, up_tgt = '0;
  logic        up_valid = 1'b0, up_taken = 1'b0;
  logic        hit0, tk0, hit1, tk1;
  logic [15:0] tg0, tg1;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lhist_btb #(.REDUCED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_tgt(lk_tgt),
    .lk_hit(hit0), .lk_taken(tk0), .lk_target(tg0),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_tgt(up_tgt));

  lhist_btb #(.REDUCED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_tgt(lk_tgt),
    .lk_hit(hit1), .lk_taken(tk1), .lk_target(tg1),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_tgt(up_tgt));

  // arithmetic model: [layout][entry]
  int mv [2][4];
  int mt [2][4];
  int mg [2][4];
  int mh [2][4];
  int mc [2][4][32];

  function automatic int slot(int pc); return (pc / 4) % 4; endfunction
  function automatic int tagof(int pc); return pc / 16; endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_look(int d, int pc, int tg, output int h, output int t, output int g);
    int i, n;
    i = slot(pc);
    n = d ? 29 : 32;
    h = (mv[d][i] != 0 && mt[d][i] == tagof(pc)) ? 1 : 0;
    if (h == 0) begin t = (tg < pc); g = tg; end
    else begin
      g = mg[d][i];
      if (mh[d][i] < n) t = (mc[d][i][mh[d][i]] >= 2);
      else t = (mg[d][i] < pc);
    end
  endtask

  task automatic model_upd(int pc, int tk, int tg);
    for (int d = 0; d < 2; d++) begin
      int i, n;
      i = slot(pc);
      n = d ? 29 : 32;
      if (mv[d][i] != 0 && mt[d][i] == tagof(pc)) begin
        mg[d][i] = tg;
        if (mh[d][i] < n) begin
          if (tk != 0) mc[d][i][mh[d][i]] = (mc[d][i][mh[d][i]] < 3) ? mc[d][i][mh[d][i]] + 1 : 3;
          else         mc[d][i][mh[d][i]] = (mc[d][i][mh[d][i]] > 0) ? mc[d][i][mh[d][i]] - 1 : 0;
        end
        mh[d][i] = (mh[d][i] * 2 + tk) % 32;
      end else begin
        mv[d][i] = 1; mt[d][i] = tagof(pc); mg[d][i] = tg; mh[d][i] = 0;
        for (int k = 0; k < 32; k++) mc[d][i][k] = (tg < pc) ? 2 : 1;
      end
    end
  endtask

  // look up pc on both layouts, compare to model, return u0 direction
  task automatic look(string req, int pc, int tg, output int pred0);
    int h, t, g;
    lk_pc = 16'(pc); lk_tgt = 16'(tg);
    #2;
    model_look(0, pc, tg, h, t, g);
    check({req, " full hit"}, int'(hit0), h);
    check({req, " full dir"}, int'(tk0), t);
    check({req, " full tgt"}, int'(tg0), g);
    model_look(1, pc, tg, h, t, g);
    check({req, " reduced hit (R7)"}, int'(hit1), h);
    check({req, " reduced dir (R7)"}, int'(tk1), t);
    check({req, " reduced tgt (R7)"}, int'(tg1), g);
    pred0 = int'(tk0);
  endtask

  task automatic resolve(int pc, int tk, int tg);
    up_pc = 16'(pc); up_taken = (tk != 0); up_tgt = 16'(tg); up_valid = 1'b1;
    model_upd(pc, tk, tg);
    @(posedge clk); #1;
    up_valid = 1'b0;
  endtask

  task automatic run_pattern(string name, int pc, int tg, int bits, int period);
    int miss, p;
    miss = 0;
    for (int k = 0; k < 80; k++) begin
      int o;
      o = (bits >> (k % period)) & 1;
      look({name, " R2/R3/R5"}, pc, tg, p);
      if (k >= 40 && p != o) miss++;
      resolve(pc, o, tg);
    end
    check({name, " R4 mispredicts after warm-up"}, miss, 0);
  endtask

  initial begin
    int p;
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 4; i++) mv[d][i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8: empty after reset
    for (int a = 0; a < 16; a++) look("R8 empty", a * 4 + 16'h0400, 16'h0500, p);

    // R6: static rule, backward / forward / equal
    look("R6 backward", 16'h0100, 16'h00F0, p); check("R6 backward taken", p, 1);
    look("R6 forward", 16'h0100, 16'h0200, p);  check("R6 forward not-taken", p, 0);
    look("R6 self", 16'h0100, 16'h0100, p);     check("R6 equal not-taken", p, 0);

    // R4 patterns, mixing forward and backward targets
    run_pattern("TTNTN", 16'h1000, 16'h1400, 5'b01011, 5);
    run_pattern("all-T", 16'h1104, 16'h1000, 1, 1);
    run_pattern("alt", 16'h1208, 16'h1300, 2'b01, 2);
    run_pattern("TTN", 16'h130C, 16'h1200, 3'b011, 3);
    run_pattern("TNNN", 16'h1400, 16'h1000, 4'b0001, 4);
    run_pattern("all-N", 16'h1504, 16'h1600, 0, 1);
    run_pattern("NTTTT", 16'h1608, 16'h1700, 5'b11110, 5);

    // R5: fresh allocation on a backward branch predicts taken from counter 2
    resolve(16'h2000, 0, 16'h1F00);
    look("R5 seed backward", 16'h2000, 16'h0000, p); check("R5 backward seed taken", p, 1);
    resolve(16'h2004, 1, 16'h2100);
    look("R5 seed forward", 16'h2004, 16'hFFFF, p);  check("R5 forward seed not-taken", p, 0);

    // R1: alias at the same index replaces, old PC then misses
    resolve(16'h3010, 1, 16'h3100);
    resolve(16'h5010, 1, 16'h5100);
    look("R1 old alias", 16'h3010, 16'h3100, p);
    check("R1 old alias miss", int'(hit0), 0);
    look("R1 new alias", 16'h5010, 16'h0000, p);
    check("R1 new alias hit", int'(hit0), 1);
    check("R1 stored target", int'(tg0), 16'h5100);

    // R9: a training hit overwrites the target
    resolve(16'h5010, 1, 16'h5A00);
    look("R9 retarget", 16'h5010, 16'h0000, p);
    check("R9 new target", int'(tg0), 16'h5A00);

    // R8: reset again empties everything
    rst_n = 1'b0; @(posedge clk); #1 rst_n = 1'b1;
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 4; i++) mv[d][i] = 0;
    look("R8 after reset", 16'h5010, 16'h6000, p);
    check("R8 miss after reset", int'(hit0), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule